// File: doc/BRIEF.md
# DMA read prefetch controller

This block moves a run of bytes from host memory into a local FIFO on behalf of a local DMA consumer. Software or a local sequencer supplies a start address, a byte count and a line size, then pulses `start`. The controller requests the system bus and, once granted, spends one cycle on an address phase that always carries the cache-line read command. It then accepts 32-bit data beats and passes each one straight into the FIFO, tagged with the number of valid bytes it holds.

A burst is cut when it reaches the last word of a cache line, and the controller then requests the bus again for the next line. The byte counter drops by the number of valid bytes on every accepted beat, and it cannot go below zero. Bus ownership ends only when the counter reaches zero. A local consumer that releases its own bus has no effect, so the prefetch keeps running. When the run completes, `done` pulses for one cycle.

Both data edges use valid/ready. An upstream beat is taken only in a cycle where `m_rvalid` and `m_rready` are both high. `m_rready` follows `f_ready` during the data phase, so a full FIFO holds the beat on the bus as a wait state. `f_valid` mirrors `m_rvalid` in the data phase, so a FIFO write and a bus beat happen in the same cycle and neither side can lose a word.

Top module: `dma_rd_prefetch`

## Requirements
- R1: While `rst_n` is low, and after it rises, `m_req`, `m_addr_valid`, `m_own`, `m_rready`, `f_valid`, `busy` and `done` are all 0.
- R2: A `start` pulse in the idle state latches the address, count and line size, and `m_req` rises in the next cycle. A `start` that arrives while `busy` is high is ignored. A zero count skips the bus and raises `done` in the cycle after `start`.
- R3: The cycle after a cycle with `m_req` and `m_gnt` both high is a single address-phase cycle (`m_addr_valid`=1), and `m_cmd` is 4'b1110 (memory read line) on every address phase.
- R4: Beat addresses start at the start address with bits [1:0] cleared and step by 4 per accepted beat. Each address phase presents the address of the next beat.
- R5: `f_bytes` on each accepted beat is min(4, remaining count). The run ends after exactly ceil(count/4) beats, and the count never goes below zero.
- R6: `m_rready` is high only when `f_ready` is high. A beat moves only when `m_rvalid` and `m_rready` are both high, and `f_data` equals `m_rdata` on that beat.
- R7: A line holds 2^`line_log2` words. After the beat at the last word of a line is accepted, with count still nonzero, the controller issues a new request. The number of address phases equals the number of lines the transfer touches.
- R8: `local_release` has no effect: the beats, addresses and completion of a transfer are the same whatever it does.
- R9: `done` is a one-cycle pulse two cycles after the final beat is accepted. During the `done` cycle `m_own` and `m_req` are 0, and no request follows.
- R10: Once raised, `m_req` stays high until `m_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_addr | input | ADDR_W | Start byte address |
| start_count | input | CNT_W | Byte count |
| line_log2 | input | LSZ_W | log2 of line size in 32-bit words |
| local_release | input | 1 | Local consumer released its bus (ignored) |
| m_req | output | 1 | Bus request |
| m_gnt | input | 1 | Bus grant |
| m_addr_valid | output | 1 | Address phase |
| m_addr | output | ADDR_W | Burst address |
| m_cmd | output | 4 | Bus command, 4'b1110 in address phase |
| m_own | output | 1 | Controller owns the bus |
| m_rvalid | input | 1 | Read beat valid |
| m_rdata | input | 32 | Read beat data |
| m_rready | output | 1 | Beat accepted when high with m_rvalid |
| f_valid | output | 1 | FIFO write valid |
| f_data | output | 32 | FIFO write data |
| f_bytes | output | 3 | Valid bytes in this word (1..4) |
| f_ready | input | 1 | FIFO has space |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
`m_req` rises one cycle after `start`, and the address phase follows one cycle after a granted request. The FIFO write and the beat handshake are combinational, so both fall in the same cycle. `done` comes two cycles after the final accepted beat, or one cycle after `start` when the count is zero. The bench drives its inputs and samples the outputs at the falling edge, after a short settle delay. It records each handshake in the half cycle before the edge that completes it. It counts falling edges from the last beat to confirm the two-cycle `done` latency.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_DATA,
    S_TERM,
    S_DONE
  } rd_state_t;

  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
  localparam int unsigned BEAT_BYTES = 4;
endpackage

// File: rtl/dma_rd_bytecnt.sv
module dma_rd_bytecnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             beat,
  output logic [2:0]       beat_bytes,
  output logic             last_beat
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(dma_rd_pkg::BEAT_BYTES);

  logic [CNT_W-1:0] remain_q;

  // a full beat takes four bytes, the final one takes whatever is left
  always_comb begin
    if (remain_q >= FULL) beat_bytes = 3'd4;
    else                  beat_bytes = remain_q[2:0];
  end

  assign last_beat = (remain_q <= FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (beat) remain_q <= remain_q - {{(CNT_W-3){1'b0}}, beat_bytes};
  end
endmodule

// File: rtl/dma_rd_addrgen.sv
module dma_rd_addrgen #(
  parameter int ADDR_W = 32,
  parameter int LSZ_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LSZ_W-1:0]  load_l2,
  input  logic              beat,
  output logic [ADDR_W-1:0] addr,
  output logic              line_end
);
  localparam int WW = ADDR_W - 2;

  logic [WW-1:0]    word_q;
  logic [LSZ_W-1:0] l2_q;
  logic [WW-1:0]    mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      l2_q   <= '0;
    end else if (load) begin
      word_q <= load_addr[ADDR_W-1:2];
      l2_q   <= load_l2;
    end else if (beat) begin
      word_q <= word_q + WW'(1);
    end
  end

  assign mask     = ~({WW{1'b1}} << l2_q);
  assign line_end = ((word_q & mask) == mask);
  assign addr     = {word_q, 2'b00};
endmodule

// File: rtl/dma_rd_fsm.sv
module dma_rd_fsm
  import dma_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      start_zero,
  input  logic      gnt,
  input  logic      beat,
  input  logic      last_beat,
  input  logic      line_end,
  output rd_state_t state
);
  rd_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: if (start) nxt = start_zero ? S_DONE : S_REQ;
      S_REQ:  if (gnt)   nxt = S_ADDR;
      S_ADDR:            nxt = S_DATA;
      S_DATA: begin
        if (beat) begin
          if (last_beat)     nxt = S_TERM;
          else if (line_end) nxt = S_REQ;
        end
      end
      S_TERM:            nxt = S_DONE;
      S_DONE:            nxt = S_IDLE;
      default:           nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dma_rd_prefetch.sv
module dma_rd_prefetch
  import dma_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LSZ_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [LSZ_W-1:0]  line_log2,
  input  logic              local_release,
  output logic              m_req,
  input  logic              m_gnt,
  output logic              m_addr_valid,
  output logic [ADDR_W-1:0] m_addr,
  output logic [3:0]        m_cmd,
  output logic              m_own,
  input  logic              m_rvalid,
  input  logic [31:0]       m_rdata,
  output logic              m_rready,
  output logic              f_valid,
  output logic [31:0]       f_data,
  output logic [2:0]        f_bytes,
  input  logic              f_ready,
  output logic              busy,
  output logic              done
);
  rd_state_t   state;
  logic        load, beat, in_data, last_beat, line_end;
  logic [2:0]  beat_bytes;

  assign in_data = (state == S_DATA);
  assign load    = start && (state == S_IDLE);
  assign beat    = m_rvalid && m_rready;

  dma_rd_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_zero (start_count == '0),
    .gnt        (m_gnt),
    .beat       (beat),
    .last_beat  (last_beat),
    .line_end   (line_end),
    .state      (state)
  );

  dma_rd_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (start_count),
    .beat       (beat),
    .beat_bytes (beat_bytes),
    .last_beat  (last_beat)
  );

  dma_rd_addrgen #(.ADDR_W(ADDR_W), .LSZ_W(LSZ_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (start_addr),
    .load_l2   (line_log2),
    .beat      (beat),
    .addr      (m_addr),
    .line_end  (line_end)
  );

  assign m_req        = (state == S_REQ);
  assign m_addr_valid = (state == S_ADDR);
  assign m_cmd        = m_addr_valid ? CMD_MEM_RD_LINE : 4'b0000;
  assign m_own        = (state == S_ADDR) || in_data || (state == S_TERM);
  assign m_rready     = in_data && f_ready;
  assign f_valid      = in_data && m_rvalid;
  assign f_data       = m_rdata;
  assign f_bytes      = beat_bytes;
  assign busy         = (state != S_IDLE);
  assign done         = (state == S_DONE);
endmodule

// File: rtl/dma_rd_prefetch_chk.sv
module dma_rd_prefetch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       local_release,
  input logic       m_req,
  input logic       m_gnt,
  input logic       m_addr_valid,
  input logic [3:0] m_cmd,
  input logic       m_own,
  input logic       m_rready,
  input logic       f_valid,
  input logic [2:0] f_bytes,
  input logic       f_ready,
  input logic       busy,
  input logic       done
);
  // R3
  cmd_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_addr_valid |-> m_cmd == 4'b1110);
  // R3
  grant_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_gnt |=> m_addr_valid);
  // R3
  addr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_addr_valid |=> !m_addr_valid);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rready |-> f_ready);
  // R5
  beat_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid |-> (f_bytes != 3'd0) && (f_bytes <= 3'd4));
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_gnt |=> m_req);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_own && !m_req);
  // R8
  release_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(local_release) && busy && !done |=> busy);
endmodule

bind dma_rd_prefetch dma_rd_prefetch_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .local_release (local_release),
  .m_req         (m_req),
  .m_gnt         (m_gnt),
  .m_addr_valid  (m_addr_valid),
  .m_cmd         (m_cmd),
  .m_own         (m_own),
  .m_rready      (m_rready),
  .f_valid       (f_valid),
  .f_bytes       (f_bytes),
  .f_ready       (f_ready),
  .busy          (busy),
  .done          (done)
);

// File: tb/sim_dma_rd_prefetch.sv
`timescale 1ns/1ps
module sim_dma_rd_prefetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] start_count = '0;
  logic [2:0]  line_log2 = '0;
  logic        local_release = 1'b0;
  logic        m_req, m_addr_valid, m_own, m_rready, f_valid, busy, done;
  logic        m_gnt = 1'b0;
  logic [31:0] m_addr, f_data;
  logic [3:0]  m_cmd;
  logic        m_rvalid = 1'b0;
  logic [31:0] m_rdata = '0;
  logic [2:0]  f_bytes;
  logic        f_ready = 1'b0;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  dma_rd_prefetch u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_count(start_count), .line_log2(line_log2), .local_release(local_release),
    .m_req(m_req), .m_gnt(m_gnt), .m_addr_valid(m_addr_valid), .m_addr(m_addr),
    .m_cmd(m_cmd), .m_own(m_own), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .m_rready(m_rready), .f_valid(f_valid), .f_data(f_data), .f_bytes(f_bytes),
    .f_ready(f_ready), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0000;
  endfunction

  function automatic int exp_lines(input logic [31:0] a, input int cnt, input int l2);
    int words = (cnt + 3) / 4;
    int n = 0;
    logic [29:0] w = a[31:2];
    logic [29:0] mask = ~(30'h3FFF_FFFF << l2);
    for (int i = 0; i < words; i++)
      if (i == 0 || (((w + 30'(i)) & mask) == 30'd0)) n++;
    return n;
  endfunction

  // stall: hold f_ready low for the first 30 cycles
  task automatic run_xfer(input logic [31:0] a, input int cnt, input int l2,
                          input bit stray, input bit stall);
    logic [31:0] exp_addr = {a[31:2], 2'b00};
    logic [31:0] slave_addr = '0;
    int remaining = cnt;
    int beats = 0, phases = 0, done_seen = 0, since_last = -1, cyc = 0;
    bit finished = 0;
    int xl = exp_lines(a, cnt, l2);
    @(negedge clk);
    start_addr = a; start_count = 16'(cnt); line_log2 = 3'(l2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_addr = $urandom; start_count = 16'($urandom); line_log2 = 3'($urandom);
    if (cnt > 0) chk(m_req == 1'b1, "R2 request after start", m_req, 1);
    while (!finished && cyc < 4000) begin
      start = (stray && cyc == 5);
      if (start) begin start_addr = 32'hDEAD_0000; start_count = 16'd8; end
      m_gnt = m_req && ($urandom % 3 == 0);
      m_rvalid = ($urandom % 4 != 0);
      f_ready = (stall && cyc < 30) ? 1'b0 : ($urandom % 4 != 0);
      m_rdata = pat(slave_addr);
      local_release = $urandom % 2;
      #1;
      if (since_last >= 0) since_last++;
      if (m_rready && !f_ready) chk(0, "R6 ready without fifo space", m_rready, 0);
      if (stall && cyc < 30 && m_rready) chk(0, "R6 stall held", m_rready, 0);
      if (m_addr_valid) begin
        chk(m_cmd == 4'b1110, "R3 line read command", m_cmd, 4'b1110);
        chk(m_addr == exp_addr, "R4 R7 burst address", m_addr, exp_addr);
        phases++;
        slave_addr = m_addr;
      end
      if (done) begin
        done_seen++;
        finished = 1;
        if (cnt == 0) chk(cyc == 0, "R2 zero count done latency", cyc, 0);
        else chk(since_last == 2, "R9 done latency", since_last, 2);
        chk(!m_own && !m_req, "R9 released at done", {m_own, m_req}, 0);
      end
      if (m_rvalid && m_rready) begin
        int eb = remaining >= 4 ? 4 : remaining;
        chk(f_valid == 1'b1, "R6 fifo write with beat", f_valid, 1);
        chk(f_data == pat(exp_addr), "R6 R4 data", f_data, pat(exp_addr));
        chk(f_bytes == 3'(eb), "R5 beat bytes", f_bytes, eb);
        remaining -= eb;
        exp_addr += 4;
        slave_addr += 4;
        beats++;
        since_last = 0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done_seen == 1, "R9 single done", done_seen, 1);
    chk(remaining == 0, "R5 count exhausted", remaining, 0);
    chk(beats == (cnt + 3) / 4, "R5 beat total R8", beats, (cnt + 3) / 4);
    chk(phases == xl, "R7 line requests", phases, xl);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(!m_req && !done && !busy, "R9 no request after done", {m_req, done, busy}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_rvalid = 1'b1; f_ready = 1'b1; m_gnt = 1'b1; start = 1'b1;
    repeat (3) @(negedge clk);
    // R1 outputs quiet during reset
    chk({m_req, m_addr_valid, m_own, m_rready, f_valid, busy, done} == 7'd0,
        "R1 reset state", {m_req, m_addr_valid, m_own, m_rready, f_valid, busy, done}, 0);
    start = 1'b0; m_gnt = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk({m_req, m_own, busy, done} == 4'd0, "R1 after reset", {m_req, m_own, busy, done}, 0);

    run_xfer(32'h0000_1000, 0,   2, 0, 0);   // R2 zero count
    run_xfer(32'h0000_2000, 1,   2, 0, 0);   // R5 single byte
    run_xfer(32'h0000_2003, 3,   2, 0, 0);   // R4 unaligned start
    run_xfer(32'h0000_3000, 4,   2, 0, 0);
    run_xfer(32'h0000_4004, 22,  0, 0, 0);   // R7 one word per line
    run_xfer(32'h0000_501C, 40,  3, 1, 0);   // R2 stray start while busy
    run_xfer(32'h0000_6008, 64,  2, 0, 1);   // R6 long stall
    run_xfer(32'h0000_7000, 130, 5, 1, 0);
    for (int i = 0; i < 20; i++)
      run_xfer($urandom, int'($urandom % 201), int'($urandom % 5), ($urandom % 2) == 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule